// File: doc/BRIEF.md
# Sixteen-Bit ALU With Status Indicators

This block is the arithmetic and logic core of a general-register instruction path. On each cycle that `opValid` is high it applies one of eight operations, chosen by a 3-bit code, to a target operand and a source operand. It presents the result and a write-enable on the same cycle, without any register in that path. At the next clock edge it updates a registered set of seven status indicators: equal, greater, overflow, carry, odd, zero and negative. Each operation code updates only its own group of indicators, and every other indicator keeps its value.

Byte-sized memory operands are zero-extended before use, so carry and overflow always come from the full 16-bit computation. The `memToReg` input gives the direction. When it is high, the memory byte is the source. When it is low, the memory byte is the target and only the low byte of the register source is used. The register file, the memory and the writeback are outside this block.

Top module: `alu_status_unit`

## Requirements
- R1: Result codes: opSel 0 passes S, 1 gives T-S, 2 gives T+S, 3 gives T AND S, 4 gives T OR S and 5 gives T XOR S, all modulo 2^16. `writeEn` is high whenever `opValid` is high and opSel is 0 to 5.
- R2: Compare (opSel 6) and test (opSel 7) never raise `writeEn`.
- R3: For opSel 0 to 5, the clock edge that ends a valid cycle loads the result flags from the result: negative takes bit 15, odd takes bit 0, and zero is set when all 16 bits are zero. For test, the same three flags are loaded from T AND S.
- R4: Compare is unsigned over all 16 bits. Greater is set when S>T, equal is set when S=T, and both are cleared when S<T. Compare leaves negative, zero and odd unchanged.
- R5: Carry is loaded on add and subtract only. For add it is the carry out of bit 15 of T+S. For subtract it is the carry out of T + NOT S + 1, so it is 1 when no borrow occurs.
- R6: On add or subtract, overflow is set when the carry into bit 15 differs from the carry out of bit 15. Otherwise it keeps its value. Only reset clears it.
- R7: Carry and overflow keep their values for every code other than add and subtract. Equal and greater keep their values for every code other than compare.
- R8: With `byteMode` high and `memToReg` high, the source is replaced by its low byte zero-extended, and the target is used in full.
- R9: With `byteMode` high and `memToReg` low, both operands are replaced by their low bytes zero-extended.
- R10: `statusQ` bit positions are 0 equal, 1 greater, 2 overflow, 3 carry, 4 odd, 5 zero and 6 negative. Reset clears all seven. When `opValid` is low, `statusQ` keeps its value and `writeEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the status register |
| opValid | input | 1 | An operation is executed this cycle |
| opSel | input | 3 | Operation code |
| tgtVal | input | 16 | Target operand T |
| srcVal | input | 16 | Source operand S |
| byteMode | input | 1 | The memory operand is a byte |
| memToReg | input | 1 | Direction: 1 memory to register, 0 register to memory |
| resultVal | output | 16 | Combinational result |
| writeEn | output | 1 | Write the result back to the target |
| statusQ | output | 7 | Registered status indicators |

## Verification
The bench targets the following cases:
- Overflow at 0x7FFF+1 and at 0x8000-1, followed by operations that must not clear overflow. A design that recomputes overflow would lose it.
- Subtracts with and without borrow, which expose an inverted carry convention.
- A compare with bit 15 set in the source, where signed logic gives the wrong greater flag.
- Test results that must not raise the write-enable.
- Byte operands with high upper bytes in both directions. A design that does not zero-extend would give wrong sums and wrong carries.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_SUB = 3'd1,
    OP_ADD = 3'd2,
    OP_AND = 3'd3,
    OP_IOR = 3'd4,
    OP_XOR = 3'd5,
    OP_CMP = 3'd6,
    OP_TST = 3'd7
  } aluOp_e;

  // status vector bit positions
  localparam int FLAG_W  = 7;
  localparam int FLAG_EQ = 0;
  localparam int FLAG_GT = 1;
  localparam int FLAG_OV = 2;
  localparam int FLAG_CY = 3;
  localparam int FLAG_OD = 4;
  localparam int FLAG_ZE = 5;
  localparam int FLAG_NG = 6;

  typedef enum logic [2:0] {
    RES_PASS  = 3'd0,
    RES_ADDER = 3'd1,
    RES_AND   = 3'd2,
    RES_OR    = 3'd3,
    RES_XOR   = 3'd4
  } resSel_e;

  // strobes steering the datapath
  typedef struct packed {
    logic    subMode;
    resSel_e resSel;
  } dpStrobe_t;

  // strobes steering the status register
  typedef struct packed {
    logic updNzo;
    logic updCarry;
    logic updCompare;
  } stStrobe_t;

endpackage

// File: rtl/alu_status_ctrl.sv
module alu_status_ctrl
  import alu_status_pkg::*;
(
  input  logic      opValid,
  input  logic [2:0] opSel,
  output dpStrobe_t dpStrobe,
  output stStrobe_t stStrobe,
  output logic      resWrite
);

  logic nzoSel;
  logic carrySel;
  logic cmpSel;
  logic wrSel;

  always_comb begin
    dpStrobe = '{subMode: 1'b0, resSel: RES_PASS};
    nzoSel   = 1'b1;
    carrySel = 1'b0;
    cmpSel   = 1'b0;
    wrSel    = 1'b1;
    case (aluOp_e'(opSel))
      OP_MOV: dpStrobe.resSel = RES_PASS;
      OP_SUB: begin
        dpStrobe = '{subMode: 1'b1, resSel: RES_ADDER};
        carrySel = 1'b1;
      end
      OP_ADD: begin
        dpStrobe.resSel = RES_ADDER;
        carrySel        = 1'b1;
      end
      OP_AND: dpStrobe.resSel = RES_AND;
      OP_IOR: dpStrobe.resSel = RES_OR;
      OP_XOR: dpStrobe.resSel = RES_XOR;
      OP_CMP: begin
        nzoSel = 1'b0;
        cmpSel = 1'b1;
        wrSel  = 1'b0;
      end
      OP_TST: begin
        dpStrobe.resSel = RES_AND;
        wrSel           = 1'b0;
      end
      default: wrSel = 1'b0;
    endcase
  end

  assign stStrobe = '{updNzo:     opValid & nzoSel,
                      updCarry:   opValid & carrySel,
                      updCompare: opValid & cmpSel};
  assign resWrite = opValid & wrSel;

endmodule

// File: rtl/alu_status_datapath.sv
module alu_status_datapath
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  dpStrobe_t          dpStrobe,
  input  logic [DATA_W-1:0]  tgtIn,
  input  logic [DATA_W-1:0]  srcIn,
  input  logic               byteMode,
  input  logic               memToReg,
  output logic [DATA_W-1:0]  resultOut,
  output logic [FLAG_W-1:0]  flagCand
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] opT;
  logic [DATA_W-1:0] opS;
  logic [DATA_W-1:0] addSrc;
  logic [DATA_W:0]   sumFull;
  logic              carryIntoMsb;

  // byte operands are zero-extended ahead of the adder
  logic [1:0] shrink;
  assign shrink[0] = byteMode & ~memToReg;  // target is the memory byte
  assign shrink[1] = byteMode;              // source low byte only

  logic [DATA_W-1:0] rawOp [2];
  logic [DATA_W-1:0] shapedOp [2];
  assign rawOp[0] = tgtIn;
  assign rawOp[1] = srcIn;

  for (genvar gi = 0; gi < 2; gi++) begin : g_shape
    assign shapedOp[gi] = shrink[gi]
        ? {{(DATA_W-BYTE_W){1'b0}}, rawOp[gi][BYTE_W-1:0]}
        : rawOp[gi];
  end

  assign opT = shapedOp[0];
  assign opS = shapedOp[1];

  assign addSrc  = dpStrobe.subMode ? ~opS : opS;
  assign sumFull = {1'b0, opT} + {1'b0, addSrc} + {{DATA_W{1'b0}}, dpStrobe.subMode};
  assign carryIntoMsb = opT[MSB] ^ addSrc[MSB] ^ sumFull[MSB];

  always_comb begin
    case (dpStrobe.resSel)
      RES_ADDER: resultOut = sumFull[MSB:0];
      RES_AND:   resultOut = opT & opS;
      RES_OR:    resultOut = opT | opS;
      RES_XOR:   resultOut = opT ^ opS;
      default:   resultOut = opS;
    endcase
  end

  always_comb begin
    flagCand          = '0;
    flagCand[FLAG_EQ] = (opS == opT);
    flagCand[FLAG_GT] = (opS > opT);
    flagCand[FLAG_OV] = carryIntoMsb ^ sumFull[DATA_W];
    flagCand[FLAG_CY] = sumFull[DATA_W];
    flagCand[FLAG_OD] = resultOut[0];
    flagCand[FLAG_ZE] = (resultOut == '0);
    flagCand[FLAG_NG] = resultOut[MSB];
  end

endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
  import alu_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stStrobe_t         stStrobe,
  input  logic [FLAG_W-1:0] flagCand,
  output logic [FLAG_W-1:0] statusQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      if (stStrobe.updNzo) begin
        statusQ[FLAG_NG] <= flagCand[FLAG_NG];
        statusQ[FLAG_ZE] <= flagCand[FLAG_ZE];
        statusQ[FLAG_OD] <= flagCand[FLAG_OD];
      end
      if (stStrobe.updCarry) begin
        statusQ[FLAG_CY] <= flagCand[FLAG_CY];
        statusQ[FLAG_OV] <= statusQ[FLAG_OV] | flagCand[FLAG_OV];
      end
      if (stStrobe.updCompare) begin
        statusQ[FLAG_EQ] <= flagCand[FLAG_EQ];
        statusQ[FLAG_GT] <= flagCand[FLAG_GT];
      end
    end
  end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] tgtVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              byteMode,
  input  logic              memToReg,
  output logic [DATA_W-1:0] resultVal,
  output logic              writeEn,
  output logic [FLAG_W-1:0] statusQ
);

  dpStrobe_t         dpStrobe;
  stStrobe_t         stStrobe;
  logic [FLAG_W-1:0] flagCand;

  alu_status_ctrl ctrl_i (
    .opValid  (opValid),
    .opSel    (opSel),
    .dpStrobe (dpStrobe),
    .stStrobe (stStrobe),
    .resWrite (writeEn)
  );

  alu_status_datapath #(.DATA_W(DATA_W)) dp_i (
    .dpStrobe  (dpStrobe),
    .tgtIn     (tgtVal),
    .srcIn     (srcVal),
    .byteMode  (byteMode),
    .memToReg  (memToReg),
    .resultOut (resultVal),
    .flagCand  (flagCand)
  );

  alu_status_flags flags_i (
    .clk      (clk),
    .rstN     (rstN),
    .stStrobe (stStrobe),
    .flagCand (flagCand),
    .statusQ  (statusQ)
  );

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic              writeEn,
  input logic [DATA_W-1:0] resultVal,
  input logic [6:0]        statusQ
);

  a_r1_write_result_ops: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel < 3'd6) |-> writeEn);

  a_r2_no_write_cmp_tst: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= 3'd6) |-> !writeEn);

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel < 3'd6) |=> (statusQ[5] == ($past(resultVal) == '0)));

  a_r4_cmp_keeps_nzo: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd6) |=> $stable(statusQ[6:4]));

  a_r6_ov_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[2] |=> statusQ[2]);

  a_r7_carry_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel != 3'd1 && opSel != 3'd2) |=> $stable(statusQ[3:2]));

  a_r7_compare_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel != 3'd6) |=> $stable(statusQ[1:0]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(statusQ));

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !writeEn);

endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .writeEn   (writeEn),
  .resultVal (resultVal),
  .statusQ   (statusQ)
);

// File: tb/alu_status_unit_tb_top.sv
module alu_status_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [15:0] tgtVal = '0;
  logic [15:0] srcVal = '0;
  logic        byteMode = 1'b0;
  logic        memToReg = 1'b0;
  logic [15:0] resultVal;
  logic        writeEn;
  logic [6:0]  statusQ;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_status_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .tgtVal(tgtVal), .srcVal(srcVal), .byteMode(byteMode),
    .memToReg(memToReg), .resultVal(resultVal), .writeEn(writeEn),
    .statusQ(statusQ)
  );

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [6:0]  st;
    bit          chkRes;
    string       tag;
  } item_t;

  item_t      sbQ[$];
  logic [6:0] model = '0;  // 0 eq,1 gt,2 ov,3 cy,4 od,5 ze,6 ng

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation and pushes the expected outcome
  task automatic doOp(input logic [2:0] op, input logic [15:0] t,
                      input logic [15:0] s, input logic byteMd,
                      input logic m2r, input string tag);
    logic [15:0] tt, ss, res;
    logic [16:0] full;
    item_t it;
    tt  = (byteMd && !m2r) ? {8'h00, t[7:0]} : t;
    ss  = byteMd ? {8'h00, s[7:0]} : s;
    res = '0;
    case (op)
      3'd0: res = ss;
      3'd1: begin
        full = {1'b0, tt} + {1'b0, ~ss} + 17'd1;
        res = full[15:0];
        model[3] = full[16];
        if (tt[15] != ss[15] && res[15] != tt[15]) model[2] = 1'b1;
      end
      3'd2: begin
        full = {1'b0, tt} + {1'b0, ss};
        res = full[15:0];
        model[3] = full[16];
        if (tt[15] == ss[15] && res[15] != tt[15]) model[2] = 1'b1;
      end
      3'd3: res = tt & ss;
      3'd4: res = tt | ss;
      3'd5: res = tt ^ ss;
      3'd7: res = tt & ss;
      default: res = '0;
    endcase
    if (op == 3'd6) begin
      model[0] = (ss == tt);
      model[1] = (ss > tt);
    end else begin
      model[6] = res[15];
      model[5] = (res == 16'h0);
      model[4] = res[0];
    end
    @(negedge clk);
    opValid = 1'b1; opSel = op; tgtVal = t; srcVal = s;
    byteMode = byteMd; memToReg = m2r;
    it.res = res; it.we = (op < 3'd6); it.st = model;
    it.chkRes = (op < 3'd6); it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk);
    opValid = 1'b0; opSel = 3'd2; tgtVal = 16'h7FFF; srcVal = 16'h0001;
    it.res = '0; it.we = 1'b0; it.st = model; it.chkRes = 0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic doReset();
    @(negedge clk);
    opValid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    model = '0;
  endtask

  // monitor: pops one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        if (it.chkRes) check(it.tag, "result", resultVal, it.res);
        check(it.tag, "writeEn", {15'h0, writeEn}, {15'h0, it.we});
        check(it.tag, "status", {9'h0, statusQ}, {9'h0, it.st});
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R10", "reset status", {9'h0, statusQ}, 16'h0);
    check("R10", "reset writeEn", {15'h0, writeEn}, 16'h0);

    // R1 R3 move and logic ops
    doOp(3'd0, 16'h1111, 16'h8001, 0, 1, "R1_R3_mov_neg_odd");
    doOp(3'd0, 16'hFFFF, 16'h0000, 0, 1, "R3_mov_zero");
    doOp(3'd3, 16'hF0F3, 16'h3C35, 0, 1, "R1_and");
    doOp(3'd4, 16'h8000, 16'h0002, 0, 1, "R1_or");
    doOp(3'd5, 16'hAAAA, 16'hAAAA, 0, 1, "R1_xor_zero");
    // R5 R6 add overflow then sticky
    doOp(3'd2, 16'h7FFF, 16'h0001, 0, 1, "R6_add_overflow");
    doOp(3'd0, 16'h0000, 16'h0005, 0, 1, "R6_r7_ov_kept_mov");
    doOp(3'd2, 16'hFFFF, 16'h0001, 0, 1, "R5_add_carry");
    doOp(3'd2, 16'h0001, 16'h0002, 0, 1, "R6_ov_sticky_add");
    // R5 subtract carry convention
    doOp(3'd1, 16'h0005, 16'h0003, 0, 1, "R5_sub_no_borrow");
    doOp(3'd1, 16'h0003, 16'h0005, 0, 1, "R5_sub_borrow");
    // R4 R2 compare unsigned
    doOp(3'd6, 16'h0001, 16'h8000, 0, 1, "R4_R2_cmp_gt_unsigned");
    doOp(3'd6, 16'h1234, 16'h1234, 0, 1, "R4_cmp_eq");
    doOp(3'd6, 16'hFFFE, 16'h0003, 0, 1, "R4_cmp_lt");
    doOp(3'd6, 16'h0010, 16'h0010, 0, 1, "R4_cmp_eq_again");
    doOp(3'd4, 16'h0000, 16'h0000, 0, 1, "R7_logic_keeps_eqgt");
    // R2 R3 test
    doOp(3'd7, 16'h00F0, 16'h0F0F, 0, 1, "R2_R3_tst_zero");
    doOp(3'd7, 16'h8001, 16'hFFFF, 0, 1, "R2_R3_tst_neg_odd");
    // R10 idle
    idle("R10_idle_hold");
    idle("R10_idle_hold2");
    // R8 R9 byte modes
    doOp(3'd2, 16'h1234, 16'hFFF0, 1, 1, "R8_byte_mem_src");
    doOp(3'd2, 16'hAB80, 16'h7790, 1, 0, "R9_byte_mem_tgt");
    doOp(3'd2, 16'h00FF, 16'hEE01, 1, 1, "R8_byte_no_carry");
    doOp(3'd1, 16'hFF00, 16'hFF01, 1, 0, "R9_byte_sub_borrow");
    // second overflow flavour after a fresh reset
    doReset();
    doOp(3'd1, 16'h8000, 16'h0001, 0, 1, "R6_sub_overflow");
    doOp(3'd6, 16'h0002, 16'h0001, 0, 1, "R7_cmp_keeps_carry");
    doOp(3'd7, 16'h0003, 16'h0001, 0, 1, "R6_ov_kept_tst");
    idle("R10_final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule